// File: doc/BRIEF.md
# Element-Width Layout Predictor for Whole-Register Reloads

A wide vector unit places the bytes of a register according to the element width that last wrote it. A whole-register load carries only a hint of the width that will be used next. When that hint is wrong, the first real use pays a rearrangement stall. This block sits beside the register file and picks, for every register that a whole-register load fills, the layout width that register should be written in. The register file and the byte shuffling stay outside the block.

For each of the 32 registers the block keeps a remembered width, a trust bit, the layout currently in force, the hint that came with the last load, and a flag meaning "loaded, not yet used". A whole-register store copies each affected register's current layout into its remembered width. A whole-register load uses the remembered width when the trust bit is set and the hint otherwise. The first ordinary instruction that reads a freshly loaded register reveals the width that was really needed. On a mismatch the block raises a one-cycle hiccup strobe and updates the trust bit. A free-running timer clears every trust bit at a fixed period, so stale trust does not persist.

Width codes are 0, 1, 2 and 3 for 8, 16, 32 and 64 bits. A group-size code c selects 2^c consecutive registers (1, 2, 4 or 8). All results appear one clock after the event that causes them.

Top module: `vlayout_predictor`

## Requirements
- R1: After reset every remembered width is code 0 (8 bits), all trust bits and loaded flags are clear, and `lay_vld`, `lay_eew`, `hiccup` and `err` are 0. In any cycle after a cycle with no event strobe, all four outputs are 0.
- R2: One cycle after an accepted load, `lay_vld` is 1 for one cycle. Field i of `lay_eew` (bits 2i+1:2i) gives the chosen layout width of register `ld_base`+i. The chosen width is that register's remembered width if its trust bit is set, and `ld_hint[1:0]` otherwise. The chosen width becomes the register's current layout and marks the register as loaded.
- R3: The group-size code c (0..3) covers 2^c consecutive registers starting at the base. Each register in the group keeps its own state. Fields of `lay_eew` beyond the group size are 0.
- R4: An accepted store copies the current layout of each register in its group into that register's remembered width. It produces no output strobe.
- R5: A use of a register marked loaded compares `use_eew` with the register's current layout. On a mismatch, `hiccup` is 1 in the next cycle. The use then clears the loaded flag and sets the current layout to `use_eew`. A use of a register not marked loaded has no effect and never raises `hiccup`.
- R6: On a hiccup, the trust bit is set if the remembered width equals `use_eew` and the load hint does not. The trust bit is cleared if the hint equals `use_eew` and the remembered width does not. Otherwise the trust bit is unchanged.
- R7: All trust bits are cleared once every 2^`SWEEP_LOG2` cycles (default 1024), counted from reset release.
- R8: A load or store whose base plus group size exceeds 32 raises `err` for one cycle in the next cycle, gives no `lay_vld`, and leaves all state unchanged. A group ending exactly at register 31 is accepted.
- R9: A load whose hint has bit 2 set (codes 4..7, reserved) is rejected the same way as in R8.
- R10: If several strobes arrive in the same cycle, the load wins over the store and the store wins over the use. Lower-priority events in that cycle are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_valid | input | 1 | Whole-register load event |
| ld_base | input | 5 | First register of the load group |
| ld_cnt | input | 2 | Load group-size code (2^c registers) |
| ld_hint | input | 3 | Encoded width hint of the load |
| st_valid | input | 1 | Whole-register store event |
| st_base | input | 5 | First register of the store group |
| st_cnt | input | 2 | Store group-size code |
| use_valid | input | 1 | Ordinary instruction reads a register |
| use_reg | input | 5 | Register being read |
| use_eew | input | 2 | Width code of that read |
| lay_vld | output | 1 | Layout result valid (one cycle) |
| lay_eew | output | 16 | Chosen width per group member, 2 bits each |
| hiccup | output | 1 | Rearrangement needed on first use |
| err | output | 1 | Event rejected |

## Verification
Loads are tried first with the trust bit clear and then set, which separates hint selection from remembered-width selection. Groups of 1 and 4 registers in which only one member learns show that state is kept per register and that the unused fields stay zero. Mismatching uses with different remembered-width and hint combinations cover the set, clear and keep branches of the trust update, and a mismatching use of a register that was never loaded must stay silent. Groups ending exactly at register 31 and one past it, reserved hints, strobes arriving together, and a load after the sweep period has passed cover the rejection, priority and periodic-clear behaviour.

// File: rtl/vlp_pkg.sv
package vlp_pkg;
  typedef enum logic [1:0] {
    EEW_8  = 2'd0,
    EEW_16 = 2'd1,
    EEW_32 = 2'd2,
    EEW_64 = 2'd3
  } eew_e;
  localparam int HINT_W = 3;
endpackage

// File: rtl/vlp_group_dec.sv
module vlp_group_dec #(
  parameter int NREG  = 32,
  parameter int CNT_W = 2
) (
  input  logic [$clog2(NREG)-1:0] base,
  input  logic [CNT_W-1:0]        cnt,
  output logic [NREG-1:0]         mask,
  output logic                    overflow
);
  localparam int IDX_W = $clog2(NREG);
  localparam int SW    = IDX_W + (1 << CNT_W);

  logic [SW-1:0] span_w;
  logic [SW-1:0] end_w;

  always_comb begin
    span_w   = SW'(1) << cnt;
    end_w    = SW'(base) + span_w;
    overflow = end_w > SW'(NREG);
  end

  for (genvar r = 0; r < NREG; r++) begin : g_mask
    assign mask[r] = (SW'(r) >= SW'(base)) && (SW'(r) < end_w);
  end
endmodule

// File: rtl/vlp_sweep_timer.sv
module vlp_sweep_timer #(
  parameter int SWEEP_LOG2 = 10
) (
  input  logic clk,
  input  logic rst_n,
  output logic sweep
);
  logic [SWEEP_LOG2-1:0] cnt_q;
  logic [SWEEP_LOG2-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q + 1'b1;
    sweep = &cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/vlp_state_table.sv
module vlp_state_table
  import vlp_pkg::*;
#(
  parameter int NREG = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    sweep,
  input  logic                    ld_en,
  input  logic [NREG-1:0]         ld_mask,
  input  eew_e                    ld_hint,
  input  logic                    st_en,
  input  logic [NREG-1:0]         st_mask,
  input  logic                    use_en,
  input  logic [$clog2(NREG)-1:0] use_idx,
  input  eew_e                    use_eew,
  output logic [NREG-1:0][1:0]    choice,
  output logic                    hiccup_d
);
  localparam int IDX_W = $clog2(NREG);

  logic [NREG-1:0][1:0] pred_q, pred_d;
  logic [NREG-1:0][1:0] lay_q,  lay_d;
  logic [NREG-1:0][1:0] hint_q, hint_d;
  logic [NREG-1:0]      trust_q, trust_d;
  logic [NREG-1:0]      pend_q,  pend_d;

  always_comb begin
    for (int r = 0; r < NREG; r++) begin
      choice[r] = trust_q[r] ? pred_q[r] : ld_hint;
    end
  end

  always_comb begin
    pred_d   = pred_q;
    lay_d    = lay_q;
    hint_d   = hint_q;
    trust_d  = trust_q;
    pend_d   = pend_q;
    hiccup_d = 1'b0;
    for (int r = 0; r < NREG; r++) begin
      if (ld_en && ld_mask[r]) begin
        lay_d[r]  = choice[r];
        hint_d[r] = ld_hint;
        pend_d[r] = 1'b1;
      end else if (st_en && st_mask[r]) begin
        pred_d[r] = lay_q[r];
      end else if (use_en && (use_idx == IDX_W'(r)) && pend_q[r]) begin
        pend_d[r] = 1'b0;
        lay_d[r]  = use_eew;
        if (lay_q[r] != use_eew) begin
          hiccup_d = 1'b1;
          if ((pred_q[r] == use_eew) && (hint_q[r] != use_eew))
            trust_d[r] = 1'b1;
          else if ((hint_q[r] == use_eew) && (pred_q[r] != use_eew))
            trust_d[r] = 1'b0;
        end
      end
      if (sweep) trust_d[r] = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pred_q  <= '0;
      lay_q   <= '0;
      hint_q  <= '0;
      trust_q <= '0;
      pend_q  <= '0;
    end else begin
      pred_q  <= pred_d;
      lay_q   <= lay_d;
      hint_q  <= hint_d;
      trust_q <= trust_d;
      pend_q  <= pend_d;
    end
  end
endmodule

// File: rtl/vlayout_predictor.sv
module vlayout_predictor
  import vlp_pkg::*;
#(
  parameter int NREG       = 32,
  parameter int CNT_W      = 2,
  parameter int SWEEP_LOG2 = 10
) (
  input  logic                                    clk,
  input  logic                                    rst_n,
  input  logic                                    ld_valid,
  input  logic [$clog2(NREG)-1:0]                 ld_base,
  input  logic [CNT_W-1:0]                        ld_cnt,
  input  logic [HINT_W-1:0]                       ld_hint,
  input  logic                                    st_valid,
  input  logic [$clog2(NREG)-1:0]                 st_base,
  input  logic [CNT_W-1:0]                        st_cnt,
  input  logic                                    use_valid,
  input  logic [$clog2(NREG)-1:0]                 use_reg,
  input  logic [1:0]                              use_eew,
  output logic                                    lay_vld,
  output logic [2*(1<<((1<<CNT_W)-1))-1:0]        lay_eew,
  output logic                                    hiccup,
  output logic                                    err
);
  localparam int IDX_W = $clog2(NREG);
  localparam int GMAX  = 1 << ((1 << CNT_W) - 1);
  localparam int VEC_W = 2 * GMAX;

  logic [NREG-1:0]      ld_mask, st_mask;
  logic                 ld_ovf, st_ovf;
  logic                 ld_bad, ld_ok, st_ok, use_ok, err_d;
  logic                 sweep, hiccup_d;
  logic [NREG-1:0][1:0] choice;
  logic [VEC_W-1:0]     vec_d;
  logic [IDX_W-1:0]     idx;

  vlp_group_dec #(.NREG(NREG), .CNT_W(CNT_W)) u_ld_dec (
    .base(ld_base), .cnt(ld_cnt), .mask(ld_mask), .overflow(ld_ovf));

  vlp_group_dec #(.NREG(NREG), .CNT_W(CNT_W)) u_st_dec (
    .base(st_base), .cnt(st_cnt), .mask(st_mask), .overflow(st_ovf));

  vlp_sweep_timer #(.SWEEP_LOG2(SWEEP_LOG2)) u_timer (
    .clk(clk), .rst_n(rst_n), .sweep(sweep));

  always_comb begin
    ld_bad = ld_ovf || ld_hint[HINT_W-1];
    ld_ok  = ld_valid && !ld_bad;
    st_ok  = st_valid && !ld_valid && !st_ovf;
    use_ok = use_valid && !ld_valid && !st_valid;
    err_d  = ld_valid ? ld_bad : (st_valid && st_ovf);
  end

  vlp_state_table #(.NREG(NREG)) u_table (
    .clk(clk), .rst_n(rst_n), .sweep(sweep),
    .ld_en(ld_ok), .ld_mask(ld_mask), .ld_hint(eew_e'(ld_hint[1:0])),
    .st_en(st_ok), .st_mask(st_mask),
    .use_en(use_ok), .use_idx(use_reg), .use_eew(eew_e'(use_eew)),
    .choice(choice), .hiccup_d(hiccup_d));

  always_comb begin
    vec_d = '0;
    idx   = '0;
    for (int i = 0; i < GMAX; i++) begin
      idx = ld_base + IDX_W'(i);
      if (i < (1 << ld_cnt)) vec_d[2*i +: 2] = choice[idx];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lay_vld <= 1'b0;
      lay_eew <= '0;
      hiccup  <= 1'b0;
      err     <= 1'b0;
    end else begin
      lay_vld <= ld_ok;
      lay_eew <= ld_ok ? vec_d : '0;
      hiccup  <= hiccup_d;
      err     <= err_d;
    end
  end
endmodule

// File: rtl/vlayout_predictor_chk.sv
module vlayout_predictor_chk #(
  parameter int NREG  = 32,
  parameter int CNT_W = 2,
  parameter int VEC_W = 16
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    ld_valid,
  input logic [CNT_W-1:0]        ld_cnt,
  input logic [2:0]              ld_hint,
  input logic                    st_valid,
  input logic                    use_valid,
  input logic                    lay_vld,
  input logic [VEC_W-1:0]        lay_eew,
  input logic                    hiccup,
  input logic                    err
);
  AST_QUIET_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !(ld_valid || st_valid || use_valid) |=> !(lay_vld || hiccup || err)); // R1

  AST_LAYOUT_NEEDS_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    lay_vld |-> $past(ld_valid)); // R2

  AST_SINGLE_FIELD_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (lay_vld && ($past(ld_cnt) == '0)) |-> (lay_eew[VEC_W-1:2] == '0)); // R3

  AST_HICCUP_NEEDS_USE: assert property (@(posedge clk) disable iff (!rst_n)
    hiccup |-> ($past(use_valid) && !$past(ld_valid) && !$past(st_valid))); // R10

  AST_ERR_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (!lay_vld && !hiccup)); // R8

  AST_RESERVED_HINT: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_valid && ld_hint[2]) |=> (err && !lay_vld)); // R9
endmodule

bind vlayout_predictor vlayout_predictor_chk #(
  .NREG(NREG), .CNT_W(CNT_W), .VEC_W(VEC_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_cnt(ld_cnt),
  .ld_hint(ld_hint), .st_valid(st_valid), .use_valid(use_valid),
  .lay_vld(lay_vld), .lay_eew(lay_eew), .hiccup(hiccup), .err(err)
);

// File: tb/vlayout_predictor_tb.sv
`timescale 1ns/1ps
module vlayout_predictor_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ld_valid = 1'b0, st_valid = 1'b0, use_valid = 1'b0;
  logic [4:0]  ld_base = '0, st_base = '0, use_reg = '0;
  logic [1:0]  ld_cnt = '0, st_cnt = '0, use_eew = '0;
  logic [2:0]  ld_hint = '0;
  logic        lay_vld, hiccup, err;
  logic [15:0] lay_eew;

  always #2 clk = ~clk;

  vlayout_predictor u_dut (
    .clk(clk), .rst_n(rst_n),
    .ld_valid(ld_valid), .ld_base(ld_base), .ld_cnt(ld_cnt), .ld_hint(ld_hint),
    .st_valid(st_valid), .st_base(st_base), .st_cnt(st_cnt),
    .use_valid(use_valid), .use_reg(use_reg), .use_eew(use_eew),
    .lay_vld(lay_vld), .lay_eew(lay_eew), .hiccup(hiccup), .err(err));

  typedef struct {
    int          due;
    bit          vld;
    logic [15:0] vec;
    bit          hic;
    bit          er;
    string       req;
  } exp_t;

  exp_t q[$];
  int   cyc = 0;
  int   checks = 0;
  int   fails = 0;
  int   m_pred[32], m_lay[32], m_hint[32], m_trust[32], m_pend[32];

  always @(posedge clk) cyc <= cyc + 1;

  // monitor: pops the expected item due in this cycle and compares
  always @(negedge clk) begin
    if (q.size() > 0 && q[0].due == cyc) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (lay_vld !== e.vld || lay_eew !== e.vec || hiccup !== e.hic || err !== e.er) begin
        fails++;
        $display("FAIL %s: got vld=%0b vec=%h hic=%0b err=%0b expected vld=%0b vec=%h hic=%0b err=%0b",
                 e.req, lay_vld, lay_eew, hiccup, err, e.vld, e.vec, e.hic, e.er);
      end
    end else if (rst_n && (lay_vld || hiccup || err)) begin
      checks++;
      fails++;
      $display("FAIL R1: unexpected strobe vld=%0b hic=%0b err=%0b expected all 0",
               lay_vld, hiccup, err);
    end
  end

  // driver: applies one cycle of strobes, updates the reference model, pushes expectation
  task automatic evt(input bit l, input int lb, input int lc, input int lh,
                     input bit s, input int sb, input int sc,
                     input bit u, input int ur, input int ue, input string req);
    exp_t e;
    int span;
    e.vld = 0; e.vec = '0; e.hic = 0; e.er = 0; e.req = req;
    if (l) begin
      span = 1 << lc;
      if (lb + span > 32 || lh > 3) e.er = 1;
      else begin
        e.vld = 1;
        for (int i = 0; i < span; i++) begin
          int r, ch;
          r  = lb + i;
          ch = m_trust[r] ? m_pred[r] : lh;
          e.vec[2*i +: 2] = 2'(ch);
          m_lay[r] = ch; m_hint[r] = lh; m_pend[r] = 1;
        end
      end
    end else if (s) begin
      span = 1 << sc;
      if (sb + span > 32) e.er = 1;
      else for (int i = 0; i < span; i++) m_pred[sb+i] = m_lay[sb+i];
    end else if (u) begin
      if (m_pend[ur] != 0) begin
        if (ue != m_lay[ur]) begin
          e.hic = 1;
          if (m_pred[ur] == ue && m_hint[ur] != ue) m_trust[ur] = 1;
          else if (m_hint[ur] == ue && m_pred[ur] != ue) m_trust[ur] = 0;
        end
        m_pend[ur] = 0;
        m_lay[ur]  = ue;
      end
    end
    ld_valid = l; ld_base = 5'(lb); ld_cnt = 2'(lc); ld_hint = 3'(lh);
    st_valid = s; st_base = 5'(sb); st_cnt = 2'(sc);
    use_valid = u; use_reg = 5'(ur); use_eew = 2'(ue);
    e.due = cyc + 1;
    q.push_back(e);
    @(negedge clk);
    ld_valid = 0; st_valid = 0; use_valid = 0;
  endtask

  task automatic load(input int b, input int c, input int h, input string req);
    evt(1, b, c, h, 0, 0, 0, 0, 0, 0, req);
  endtask
  task automatic store(input int b, input int c, input string req);
    evt(0, 0, 0, 0, 1, b, c, 0, 0, 0, req);
  endtask
  task automatic use_r(input int r, input int w, input string req);
    evt(0, 0, 0, 0, 0, 0, 0, 1, r, w, req);
  endtask

  initial begin
    #(4 * 100000);
    fails++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int r = 0; r < 32; r++) begin
      m_pred[r] = 0; m_lay[r] = 0; m_hint[r] = 0; m_trust[r] = 0; m_pend[r] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    checks++;
    if (lay_vld !== 0 || lay_eew !== 0 || hiccup !== 0 || err !== 0) begin
      fails++;
      $display("FAIL R1: reset outputs vld=%0b vec=%h hic=%0b err=%0b expected 0 0 0 0",
               lay_vld, lay_eew, hiccup, err);
    end

    load(0, 0, 2, "R2 hint used when untrusted");
    use_r(0, 2, "R5 matching first use");
    use_r(0, 3, "R5 use of unloaded register silent");

    load(4, 0, 1, "R2 hint on reg4");
    use_r(4, 0, "R6 mismatch sets trust");
    load(4, 0, 1, "R2 remembered width used when trusted");
    use_r(4, 0, "R5 matching use after trusted load");

    load(8, 2, 3, "R3 group of four");
    use_r(9, 1, "R6 mismatch neither matches");
    store(8, 2, "R4 store group");
    load(8, 2, 2, "R3 group after store");
    use_r(9, 1, "R6 remembered matches, trust set");
    load(8, 2, 2, "R3 per-register choice in group");
    use_r(9, 2, "R6 hint matches, trust cleared");
    load(9, 0, 2, "R6 untrusted again");

    load(30, 0, 1, "R8 reg30 setup");
    use_r(30, 2, "R8 reg30 setup use");
    store(30, 0, "R4 store single");
    load(30, 0, 1, "R4 hint before trust");
    use_r(30, 2, "R6 learn reg30");
    load(30, 0, 1, "R2 trusted reg30");
    use_r(30, 3, "R6 reg30 lay change");
    store(28, 3, "R8 store past end rejected");
    load(30, 0, 1, "R8 state unchanged after rejected store");
    load(29, 2, 3, "R8 load past end rejected");
    load(24, 3, 0, "R8 group ending at 31 accepted");
    load(31, 0, 1, "R8 last register alone");

    load(4, 0, 5, "R9 reserved hint rejected");
    load(4, 0, 1, "R9 state unchanged after reserved hint");

    evt(1, 12, 0, 1, 0, 0, 0, 1, 9, 3, "R10 load beats use");
    use_r(9, 3, "R10 ignored use left register loaded");
    evt(0, 0, 0, 0, 1, 9, 0, 1, 9, 0, "R10 store beats use");

    repeat (1100) @(negedge clk);
    for (int r = 0; r < 32; r++) m_trust[r] = 0;
    load(4, 0, 1, "R7 trust swept on reg4");
    load(30, 0, 3, "R7 trust swept on reg30");

    repeat (4) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule